// File: doc/BRIEF.md
# Protected Standby Control Register

This block holds an 8-bit control register that puts the processor into standby and decides what may bring it out. Software can change the register only through a two-step sequence. First it writes any value to a separate command address. The very next bus access must then be the write to the control register. A write that lacks this unlock, or that breaks the programming rules, changes nothing and raises a sticky protection-error flag.

The register has three live bits. One blocks release by the NMI edge. One blocks release by unmasked maskable interrupts. The third is the standby bit: writing 1 to it enters the standby mode chosen elsewhere (IDLE or STOP). When an enabled release source fires, hardware clears the standby bit and sends out a one-cycle wake pulse. The release-block bits must be programmed in an earlier write than the one that sets the standby bit. The register accepts whole-byte writes and single-bit set, clear and invert operations.

Top module: `standby_guard`

## Requirements
- R1: After a synchronous reset the register reads 0x00 and stby_req, stby_stop, wake_pulse and prot_err are all 0.
- R2: A write to the control address that is not immediately preceded by a write to the command address leaves the register unchanged and sets prot_err. prot_err then stays at 1 until reset.
- R3: Any bus access between the command write and the control write cancels the unlock, so the control write is rejected as in R2.
- R4: Bit 5 blocks NMI release, bit 4 blocks interrupt release and bit 1 is the standby bit. Writes to bits 7, 6, 3, 2 and 0 are ignored, and those bits always read 0.
- R5: bus_op selects the update: 0 writes the whole byte, 1 sets bit bus_bit, 2 clears it and 3 inverts it. Every one of these operations needs the unlock.
- R6: If an update would leave the standby bit at 1 while changing bit 5 or bit 4, the whole update is rejected and prot_err is set.
- R7: stby_req equals the standby bit. stby_stop captures mode_stop at the moment of entry and is 0 whenever stby_req is 0.
- R8: While in standby with bit 5 at 0, a rising edge on nmi_pin releases standby. With bit 5 at 1, an NMI edge has no effect.
- R9: While in standby with bit 4 at 0, any request whose mask bit is 0 releases standby. A masked request never releases standby, and with bit 4 at 1 no interrupt releases it.
- R10: A release clears the standby bit one clock after the event. In that same cycle wake_pulse is 1, and it lasts for exactly one cycle.
- R11: If a release event is present in the cycle of the write that sets the standby bit, the write is followed at once by a release: the next cycle shows stby_req at 0 and wake_pulse at 1.
- R12: A read of the control address returns the register on bus_rdata one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_op | input | 2 | Write kind: 0 byte, 1 set bit, 2 clear bit, 3 invert bit |
| bus_bit | input | 3 | Bit index for single-bit operations |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Registered read data |
| nmi_pin | input | 1 | NMI input, rising edge is the event |
| irq_req | input | N_IRQ | Maskable interrupt requests |
| irq_mask | input | N_IRQ | Mask per request, 1 = masked |
| mode_stop | input | 1 | Selected mode: 1 = STOP, 0 = IDLE |
| stby_req | output | 1 | Standby in effect |
| stby_stop | output | 1 | Standby is the STOP kind |
| wake_pulse | output | 1 | One-cycle release indication |
| prot_err | output | 1 | Sticky protection-error flag |

## Verification
A stale unlock flag shows up on the very next control write: the register changes when it should not, or prot_err fails to rise, and a read one cycle later exposes it. A wrong standby bit is visible at once on stby_req. A wrong release decode either loses the wake pulse or emits it one clock after an edge or request that should have been ignored. Sweeping every byte value and every single-bit operation from each release setting exposes mistakes in the bit mask and in the rejection rule within two cycles of the write.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned BIT_NMI_DIS = 5;
  localparam int unsigned BIT_INT_DIS = 4;
  localparam int unsigned BIT_STBY    = 1;
  localparam logic [REG_W-1:0] LIVE_MASK = 8'h32;

  typedef enum logic [1:0] {
    OP_BYTE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_INV  = 2'd3
  } sg_op_e;
endpackage

// File: rtl/sg_unlock.sv
module sg_unlock #(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ctl_wr,
  output logic              ctl_rd,
  output logic              unlocked
);
  logic armed_q;

  assign ctl_wr   = bus_valid && bus_write && (bus_addr == CTL_ADDR);
  assign ctl_rd   = bus_valid && !bus_write && (bus_addr == CTL_ADDR);
  assign unlocked = armed_q;

  // Any access re-evaluates the unlock: only a command write leaves it armed.
  always_ff @(posedge clk) begin
    if (rst)
      armed_q <= 1'b0;
    else if (bus_valid)
      armed_q <= bus_write && (bus_addr == CMD_ADDR);
  end
endmodule

// File: rtl/sg_wake.sv
module sg_wake #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_pin,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             nmi_block,
  input  logic             int_block,
  output logic             release_evt
);
  logic nmi_prev_q;
  logic nmi_rise;
  logic irq_hit;

  always_ff @(posedge clk) begin
    if (rst)
      nmi_prev_q <= 1'b0;
    else
      nmi_prev_q <= nmi_pin;
  end

  assign nmi_rise    = nmi_pin && !nmi_prev_q;
  assign irq_hit     = |(irq_req & ~irq_mask);
  assign release_evt = (nmi_rise && !nmi_block) || (irq_hit && !int_block);
endmodule

// File: rtl/sg_core.sv
module sg_core
  import sg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic             unlocked,
  input  logic [1:0]       op,
  input  logic [2:0]       bitsel,
  input  logic [REG_W-1:0] wdata,
  input  logic             release_evt,
  input  logic             mode_stop,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] rdata,
  output logic             stby_stop,
  output logic             wake,
  output logic             prot_err
);
  logic [REG_W-1:0] cand;
  logic [REG_W-1:0] cand_m;
  logic [REG_W-1:0] next_v;
  logic [REG_W-1:0] onehot;
  logic             illegal;
  logic             accept;
  logic             err_now;
  logic             wake_d;

  assign onehot = REG_W'(1) << bitsel;

  always_comb begin
    unique case (sg_op_e'(op))
      OP_BYTE: cand = wdata;
      OP_SET:  cand = ctl_q | onehot;
      OP_CLR:  cand = ctl_q & ~onehot;
      OP_INV:  cand = ctl_q ^ onehot;
      default: cand = ctl_q;
    endcase
  end

  assign cand_m  = cand & LIVE_MASK;
  assign illegal = cand_m[BIT_STBY] &&
                   ((cand_m[BIT_NMI_DIS] != ctl_q[BIT_NMI_DIS]) ||
                    (cand_m[BIT_INT_DIS] != ctl_q[BIT_INT_DIS]));
  assign accept  = ctl_wr && unlocked && !illegal;
  assign err_now = ctl_wr && (!unlocked || illegal);

  always_comb begin
    next_v = accept ? cand_m : ctl_q;
    wake_d = 1'b0;
    if (next_v[BIT_STBY] && release_evt) begin
      next_v[BIT_STBY] = 1'b0;
      wake_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      rdata     <= '0;
      stby_stop <= 1'b0;
      wake      <= 1'b0;
      prot_err  <= 1'b0;
    end else begin
      ctl_q    <= next_v;
      wake     <= wake_d;
      prot_err <= prot_err || err_now;
      if (ctl_rd)
        rdata <= ctl_q;
      if (!next_v[BIT_STBY])
        stby_stop <= 1'b0;
      else if (!ctl_q[BIT_STBY])
        stby_stop <= mode_stop;
    end
  end
endmodule

// File: rtl/standby_guard.sv
module standby_guard
  import sg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned N_IRQ  = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_op,
  input  logic [2:0]        bus_bit,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              nmi_pin,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_mask,
  input  logic              mode_stop,
  output logic              stby_req,
  output logic              stby_stop,
  output logic              wake_pulse,
  output logic              prot_err
);
  logic             ctl_wr;
  logic             ctl_rd;
  logic             unlocked;
  logic             release_evt;
  logic [REG_W-1:0] ctl_q;

  sg_unlock #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .CTL_ADDR(CTL_ADDR)) u_unlock (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .unlocked(unlocked)
  );

  sg_wake #(.N_IRQ(N_IRQ)) u_wake (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .irq_req(irq_req),
    .irq_mask(irq_mask), .nmi_block(ctl_q[BIT_NMI_DIS]),
    .int_block(ctl_q[BIT_INT_DIS]), .release_evt(release_evt)
  );

  sg_core u_core (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .unlocked(unlocked),
    .op(bus_op), .bitsel(bus_bit), .wdata(bus_wdata), .release_evt(release_evt),
    .mode_stop(mode_stop), .ctl_q(ctl_q), .rdata(bus_rdata),
    .stby_stop(stby_stop), .wake(wake_pulse), .prot_err(prot_err)
  );

  assign stby_req = ctl_q[BIT_STBY];
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              stby_req,
  input logic              stby_stop,
  input logic              wake_pulse,
  input logic              prot_err
);
  logic ctl_write;
  assign ctl_write = bus_valid && bus_write && (bus_addr == CTL_ADDR);

  assert_dead_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & 8'hCD) == 8'h00);

  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    prot_err |=> prot_err);

  assert_entry_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(stby_req) |-> $past(ctl_write));

  assert_stop_needs_stby_R7: assert property (@(posedge clk) disable iff (rst)
    stby_stop |-> stby_req);

  assert_wake_clears_R10: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> !stby_req);

  assert_wake_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  assert_exit_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(stby_req) |-> (wake_pulse || $past(ctl_write)));
endmodule

bind standby_guard sg_checker #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .stby_req(stby_req),
  .stby_stop(stby_stop), .wake_pulse(wake_pulse), .prot_err(prot_err)
);

// File: tb/sim_standby_guard.sv
`timescale 1ns/1ps
module sim_standby_guard;
  localparam int unsigned AW = 4;
  localparam int unsigned NI = 8;
  localparam logic [AW-1:0] CMD = 4'h0;
  localparam logic [AW-1:0] CTL = 4'h1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0] bus_op = '0;
  logic [2:0] bus_bit = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic nmi_pin = 1'b0;
  logic [NI-1:0] irq_req = '0, irq_mask = '1;
  logic mode_stop = 1'b0;
  logic stby_req, stby_stop, wake_pulse, prot_err;

  int nchk = 0, nfail = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  standby_guard #(.ADDR_W(AW), .N_IRQ(NI), .CMD_ADDR(CMD), .CTL_ADDR(CTL)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_op(bus_op), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nmi_pin(nmi_pin), .irq_req(irq_req), .irq_mask(irq_mask),
    .mode_stop(mode_stop), .stby_req(stby_req), .stby_stop(stby_stop),
    .wake_pulse(wake_pulse), .prot_err(prot_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; nmi_pin = 1'b0; irq_req = '0; irq_mask = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a,
                        input logic [1:0] op, input logic [2:0] b, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_op = op; bus_bit = b; bus_wdata = d;
  endtask

  task automatic idle;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic prot_op(input logic [1:0] op, input logic [2:0] b, input logic [7:0] d);
    access(1'b1, CMD, 2'd0, 3'd0, 8'h00);
    access(1'b1, CTL, op, b, d);
    idle();
  endtask

  task automatic rd(output logic [7:0] v);
    access(1'b0, CTL, 2'd0, 3'd0, 8'h00);
    idle();
    v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 stby_req", stby_req, 0);
    chk("R1 wake", wake_pulse, 0);
    chk("R1 err", prot_err, 0);
    chk("R1 stop", stby_stop, 0);
    rd(rv); chk("R1/R12 read", rv, 8'h00);

    // R2: control write with no unlock
    do_reset();
    access(1'b1, CTL, 2'd0, 3'd0, 8'h20); idle();
    rd(rv); chk("R2 reg unchanged", rv, 8'h00);
    chk("R2 err set", prot_err, 1);
    prot_op(2'd0, 3'd0, 8'h10);
    chk("R2 err sticky", prot_err, 1);
    rd(rv); chk("R2 later write ok", rv, 8'h10);

    // R3: read between unlock and write cancels it
    do_reset();
    access(1'b1, CMD, 2'd0, 3'd0, 8'h5A);
    access(1'b0, CTL, 2'd0, 3'd0, 8'h00);
    access(1'b1, CTL, 2'd0, 3'd0, 8'h20);
    idle();
    rd(rv); chk("R3 cancelled", rv, 8'h00);
    chk("R3 err", prot_err, 1);

    // R4/R6/R7/R12: sweep every byte from the cleared state
    for (int d = 0; d < 256; d++) begin
      logic [7:0] v, e;
      logic ill;
      do_reset();
      mode_stop = d[0];
      v = 8'(d) & 8'h32;
      ill = v[1] && (v[5:4] != 2'b00);
      e = ill ? 8'h00 : v;
      prot_op(2'd0, 3'd0, 8'(d));
      chk("R7 stby_req", stby_req, e[1]);
      chk("R7 stby_stop", stby_stop, e[1] & d[0]);
      chk("R6 err", prot_err, ill);
      rd(rv); chk("R4 byte readback", rv, e);
      if (e[1]) begin
        @(negedge clk); irq_mask = '0; irq_req = 8'h01;
        @(negedge clk);
        chk("R10 wake", wake_pulse, 1);
        chk("R10 cleared", stby_req, 0);
        irq_req = '0;
        @(negedge clk);
        chk("R10 one cycle", wake_pulse, 0);
      end
    end
    mode_stop = 1'b0;

    // R5/R6: single-bit operations from each release setting
    for (int k = 0; k < 4; k++) begin
      for (int op = 1; op < 4; op++) begin
        for (int b = 0; b < 8; b++) begin
          logic [7:0] s, t, v, e;
          logic ill;
          s = 8'(k << 4);
          do_reset();
          prot_op(2'd0, 3'd0, s);
          case (op)
            1: t = s | (8'h01 << b);
            2: t = s & ~(8'h01 << b);
            default: t = s ^ (8'h01 << b);
          endcase
          v = t & 8'h32;
          ill = v[1] && (v[5:4] != s[5:4]);
          e = ill ? s : v;
          prot_op(2'(op), 3'(b), 8'hFF);
          chk("R5 bitop stby", stby_req, e[1]);
          chk("R6 bitop err", prot_err, ill);
          rd(rv); chk("R5 bitop readback", rv, e);
        end
      end
    end

    // R8: NMI blocked, then allowed
    do_reset();
    prot_op(2'd0, 3'd0, 8'h20);
    prot_op(2'd0, 3'd0, 8'h22);
    chk("R8 entered", stby_req, 1);
    @(negedge clk); nmi_pin = 1'b1;
    @(negedge clk);
    chk("R8 nmi blocked stby", stby_req, 1);
    chk("R8 nmi blocked wake", wake_pulse, 0);
    nmi_pin = 1'b0;
    do_reset();
    prot_op(2'd0, 3'd0, 8'h10);
    prot_op(2'd0, 3'd0, 8'h12);
    @(negedge clk); nmi_pin = 1'b1; irq_req = 8'h80; irq_mask = 8'h00;
    @(negedge clk);
    chk("R8 nmi release wake", wake_pulse, 1);
    chk("R8 nmi release stby", stby_req, 0);
    nmi_pin = 1'b0; irq_req = '0;

    // R9: masked request, then unmasked, then blocked by bit 4
    do_reset();
    irq_req = 8'h04; irq_mask = 8'h04;
    prot_op(2'd0, 3'd0, 8'h02);
    @(negedge clk);
    chk("R9 masked no release", stby_req, 1);
    irq_mask = 8'h00;
    @(negedge clk);
    chk("R9 unmasked wake", wake_pulse, 1);
    chk("R9 unmasked stby", stby_req, 0);
    irq_req = '0;
    do_reset();
    prot_op(2'd0, 3'd0, 8'h10);
    prot_op(2'd0, 3'd0, 8'h12);
    @(negedge clk); irq_req = 8'hFF; irq_mask = 8'h00;
    @(negedge clk); @(negedge clk);
    chk("R9 bit4 blocks", stby_req, 1);
    chk("R9 bit4 no wake", wake_pulse, 0);
    irq_req = '0;

    // R11: release coincident with the setting write
    do_reset();
    irq_req = 8'h02; irq_mask = 8'h00;
    prot_op(2'd0, 3'd0, 8'h02);
    chk("R11 immediate wake", wake_pulse, 1);
    chk("R11 stby clear", stby_req, 0);
    @(negedge clk);
    chk("R11 pulse ends", wake_pulse, 0);
    irq_req = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule